// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken by running two independent direction predictors side by side and letting a third table decide which one to trust. The first predictor looks at a shift register of recent outcomes from all branches. It uses that pattern to select a 2-bit saturating counter. The second predictor is specific to each branch. It first reads that branch's own recent outcome pattern from a history table addressed by the program counter, then uses the pattern to select a 3-bit saturating counter. A table of 2-bit selector counters, addressed by program counter bits, picks between the two answers.

A fetch stage presents a PC on the lookup port. One clock later the block returns the final guess, both component guesses, and which component was selected. When the branch resolves, the back end presents the PC, the real outcome, and the two component guesses it received at lookup. The block then trains both counters, trains the selector, and shifts the outcome into the shared history and into that branch's private history. Lookups read the state as it was before any update in the same cycle.

Top module: `tourney_pred`

## Requirements
- R1: While in reset and on the first cycle after it, the prediction outputs are all 0. Every cell then starts in its weak not-taken state: 2'b01 for the shared-pattern counters and 3'b011 for the per-branch counters. All histories start at zero. Every selector starts at 2'b01, which selects the per-branch predictor. A cycle without a lookup drives all prediction outputs to 0 on the next cycle.
- R2: The latency is fixed at one cycle. `pred_valid` is high exactly in the cycle after `lk_valid` was high, and the other prediction outputs belong to that lookup.
- R3: `pred_global` is bit 1 of the 2-bit counter selected by the current GH_W-bit shared history.
- R4: `pred_local` is bit 2 of the 3-bit counter selected by the branch's LH_W-bit history. That history is held in an entry addressed by PC bits [LH_IDX+PC_LSB-1:PC_LSB].
- R5: The selector entry is addressed by PC bits [CH_IDX+PC_LSB-1:PC_LSB]. `pred_use_global` is bit 1 of that entry. `pred_taken` equals `pred_global` when `pred_use_global` is 1, and `pred_local` otherwise.
- R6: A selector entry changes only on an update whose two component guesses differ. It then moves one step toward 2'b11 when the shared-pattern guess matched the outcome, and one step toward 2'b00 otherwise, saturating at both ends. When the guesses agree, the entry is left unchanged.
- R7: Every update moves both addressed counters one step toward the outcome, saturating at both ends. The shared-pattern counter is addressed by the shared history before the shift. The per-branch counter is addressed by the branch history before the shift.
- R8: Every update shifts the outcome (1 = taken) into bit 0 of the shared history and into bit 0 of the addressed branch history. Without an update, both histories hold their values.
- R9: When a lookup and an update arrive in the same cycle, the returned prediction reflects the state before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Lookup PC |
| pred_valid | output | 1 | Prediction valid (one cycle after lookup) |
| pred_taken | output | 1 | Final direction guess |
| pred_global | output | 1 | Shared-pattern component guess |
| pred_local | output | 1 | Per-branch component guess |
| pred_use_global | output | 1 | 1 when the shared-pattern guess was selected |
| up_valid | input | 1 | Resolved-branch update |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_global | input | 1 | Shared-pattern guess returned at lookup |
| up_local | input | 1 | Per-branch guess returned at lookup |

## Verification
The bench builds the predictor with PC_W=16, CH_IDX=4, GH_W=4, LH_IDX=3 and LH_W=4. The shared history therefore wraps every four outcomes, and a few updates drive any counter into saturation at either end. Branch PCs are drawn from a set wider than the selector and branch-history tables, so several branches alias onto one selector entry and one branch-history entry, and the per-branch patterns collide in the small counter table. Directed sequences push one selector across its threshold and then feed it agreeing guesses. They also overlap a lookup with an update to the same branch.

// File: rtl/tourney_pred.sv
module tourney_pred #(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int CH_IDX = 12,
  parameter int GH_W   = 12,
  parameter int LH_IDX = 10,
  parameter int LH_W   = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic            pred_global,
  output logic            pred_local,
  output logic            pred_use_global,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_global,
  input  logic            up_local
);
  localparam int CH_N = 1 << CH_IDX;
  localparam int GC_N = 1 << GH_W;
  localparam int LH_N = 1 << LH_IDX;
  localparam int LC_N = 1 << LH_W;

  logic [1:0]      ch_tbl [CH_N];
  logic [1:0]      gc_tbl [GC_N];
  logic [LH_W-1:0] lh_tbl [LH_N];
  logic [2:0]      lc_tbl [LC_N];
  logic [GH_W-1:0] ghist;

  function automatic logic [1:0] step2(input logic [1:0] v, input logic up);
    if (up) return (v == 2'b11) ? v : v + 2'd1;
    return (v == 2'b00) ? v : v - 2'd1;
  endfunction

  function automatic logic [2:0] step3(input logic [2:0] v, input logic up);
    if (up) return (v == 3'b111) ? v : v + 3'd1;
    return (v == 3'b000) ? v : v - 3'd1;
  endfunction

  wire [CH_IDX-1:0] lk_ci = lk_pc[CH_IDX+PC_LSB-1:PC_LSB];
  wire [LH_IDX-1:0] lk_li = lk_pc[LH_IDX+PC_LSB-1:PC_LSB];
  wire [LH_W-1:0]   lk_pat = lh_tbl[lk_li];
  wire              lk_g = gc_tbl[ghist][1];
  wire              lk_l = lc_tbl[lk_pat][2];
  wire              lk_sel = ch_tbl[lk_ci][1];

  wire [CH_IDX-1:0] up_ci = up_pc[CH_IDX+PC_LSB-1:PC_LSB];
  wire [LH_IDX-1:0] up_li = up_pc[LH_IDX+PC_LSB-1:PC_LSB];
  wire [LH_W-1:0]   up_pat = lh_tbl[up_li];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid      <= 1'b0;
      pred_taken      <= 1'b0;
      pred_global     <= 1'b0;
      pred_local      <= 1'b0;
      pred_use_global <= 1'b0;
    end else begin
      pred_valid      <= lk_valid;
      pred_global     <= lk_valid & lk_g;
      pred_local      <= lk_valid & lk_l;
      pred_use_global <= lk_valid & lk_sel;
      pred_taken      <= lk_valid & (lk_sel ? lk_g : lk_l);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghist <= '0;
      for (int i = 0; i < CH_N; i++) ch_tbl[i] <= 2'b01;
      for (int i = 0; i < GC_N; i++) gc_tbl[i] <= 2'b01;
      for (int i = 0; i < LH_N; i++) lh_tbl[i] <= '0;
      for (int i = 0; i < LC_N; i++) lc_tbl[i] <= 3'b011;
    end else if (up_valid) begin
      if (up_global != up_local)
        ch_tbl[up_ci] <= step2(ch_tbl[up_ci], up_global == up_taken);
      gc_tbl[ghist]  <= step2(gc_tbl[ghist], up_taken);
      lc_tbl[up_pat] <= step3(lc_tbl[up_pat], up_taken);
      ghist          <= {ghist[GH_W-2:0], up_taken};
      lh_tbl[up_li]  <= {up_pat[LH_W-2:0], up_taken};
    end
  end
endmodule

// File: rtl/tourney_pred_chk.sv
module tourney_pred_chk #(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int CH_IDX = 12,
  parameter int GH_W   = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic            up_valid,
  input logic [PC_W-1:0] up_pc,
  input logic            up_global,
  input logic            up_local,
  input logic            pred_valid,
  input logic            pred_taken,
  input logic            pred_global,
  input logic            pred_local,
  input logic            pred_use_global,
  input logic [GH_W-1:0] ghist,
  input logic [1:0]      ch_tbl [1 << CH_IDX]
);
  wire [CH_IDX-1:0] ci = up_pc[CH_IDX+PC_LSB-1:PC_LSB];

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pred_valid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !pred_valid && !pred_taken && !pred_global && !pred_local && !pred_use_global);

  a_r5_select: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> pred_taken == (pred_use_global ? pred_global : pred_local));

  a_r8_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist));

  a_r6_agree_hold: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && (up_global == up_local) |=> ch_tbl[$past(ci)] == $past(ch_tbl[ci]));
endmodule

bind tourney_pred tourney_pred_chk #(
  .PC_W(PC_W), .PC_LSB(PC_LSB), .CH_IDX(CH_IDX), .GH_W(GH_W)
) u_chk (.*);

// File: tb/sim_tourney_pred.sv
`timescale 1ns/1ps
module sim_tourney_pred;
  localparam int PC_W = 16, PC_LSB = 2, CH_IDX = 4, GH_W = 4, LH_IDX = 3, LH_W = 4;
  localparam int LIMIT = 100000;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, up_valid = 0, up_taken = 0, up_global = 0, up_local = 0;
  logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
  logic pred_valid, pred_taken, pred_global, pred_local, pred_use_global;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tourney_pred #(.PC_W(PC_W), .PC_LSB(PC_LSB), .CH_IDX(CH_IDX), .GH_W(GH_W),
                 .LH_IDX(LH_IDX), .LH_W(LH_W)) u0 (.*);

  logic [1:0]      mch [1 << CH_IDX];
  logic [1:0]      mg  [1 << GH_W];
  logic [2:0]      ml  [1 << LH_W];
  logic [LH_W-1:0] mh  [1 << LH_IDX];
  logic [GH_W-1:0] mgh;

  function automatic logic [1:0] s2(input logic [1:0] v, input logic up);
    if (up) return v == 3 ? v : v + 1;
    return v == 0 ? v : v - 1;
  endfunction
  function automatic logic [2:0] s3(input logic [2:0] v, input logic up);
    if (up) return v == 7 ? v : v + 1;
    return v == 0 ? v : v - 1;
  endfunction

  // expected {taken, global, local, use_global}
  function automatic logic [3:0] m_pred(input logic [PC_W-1:0] pc);
    logic g, l, u;
    g = mg[mgh][1];
    l = ml[mh[pc[LH_IDX+PC_LSB-1:PC_LSB]]][2];
    u = mch[pc[CH_IDX+PC_LSB-1:PC_LSB]][1];
    return {u ? g : l, g, l, u};
  endfunction

  task automatic m_reset();
    mgh = '0;
    foreach (mch[i]) mch[i] = 2'b01;
    foreach (mg[i])  mg[i]  = 2'b01;
    foreach (ml[i])  ml[i]  = 3'b011;
    foreach (mh[i])  mh[i]  = '0;
  endtask

  task automatic m_update(input logic [PC_W-1:0] pc, input logic t, input logic g, input logic l);
    logic [CH_IDX-1:0] ci;
    logic [LH_IDX-1:0] li;
    logic [LH_W-1:0] p;
    ci = pc[CH_IDX+PC_LSB-1:PC_LSB];
    li = pc[LH_IDX+PC_LSB-1:PC_LSB];
    p = mh[li];
    if (g != l) mch[ci] = s2(mch[ci], g == t);
    mg[mgh] = s2(mg[mgh], t);
    ml[p] = s3(ml[p], t);
    mgh = {mgh[GH_W-2:0], t};
    mh[li] = {p[LH_W-2:0], t};
  endtask

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (valid,taken,global,local,use_global)", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {pred_valid, pred_taken, pred_global, pred_local, pred_use_global};
  endfunction

  // lookup, optionally with a same-cycle update; called just after a falling edge
  task automatic step(input string req, input logic [PC_W-1:0] pc,
                      input bit do_up, input logic t, input logic g, input logic l,
                      output logic [3:0] got);
    logic [3:0] e;
    e = m_pred(pc);
    lk_valid = 1; lk_pc = pc;
    up_valid = do_up; up_pc = pc; up_taken = t; up_global = g; up_local = l;
    @(negedge clk);
    lk_valid = 0; up_valid = 0;
    if (do_up) m_update(pc, t, g, l);
    check(req, outs(), {1'b1, e});
    got = {pred_taken, pred_global, pred_local, pred_use_global};
  endtask

  task automatic update(input logic [PC_W-1:0] pc, input logic t, input logic g, input logic l);
    up_valid = 1; up_pc = pc; up_taken = t; up_global = g; up_local = l;
    @(negedge clk);
    up_valid = 0;
    m_update(pc, t, g, l);
  endtask

  task automatic predict_then_resolve(input string req, input logic [PC_W-1:0] pc, input logic t);
    logic [3:0] got;
    step(req, pc, 0, 0, 0, 0, got);
    update(pc, t, got[2], got[1]);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= LIMIT && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected < %0d", cycles, LIMIT);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] got;
    logic [PC_W-1:0] pcs [12];
    int seed;
    process::self().srandom(32'd7);
    seed = 1234;
    void'($urandom(seed));
    m_reset();
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", outs(), 5'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1 first cycle after reset", outs(), 5'b0);

    // R1 reset state: weak not-taken, local selected
    step("R1 initial prediction", 16'h0040, 0, 0, 0, 0, got);
    check("R1 initial prediction value", {1'b0, got}, 5'b00000);
    @(negedge clk);
    check("R2 valid drops after lookup", outs(), 5'b0);

    // R6: disagreement with global correct twice crosses the threshold
    update(16'h0040, 1, 1, 0);
    update(16'h0040, 1, 1, 0);
    step("R6 chooser moved to global", 16'h0040, 0, 0, 0, 0, got);
    check("R6 use_global set", {4'b0, got[0]}, 5'b00001);
    // R6: agreeing guesses leave it alone
    repeat (4) update(16'h0040, 0, 0, 0);
    step("R6 chooser unchanged on agreement", 16'h0040, 0, 0, 0, 0, got);
    check("R6 use_global still set", {4'b0, got[0]}, 5'b00001);
    // R6: disagreements with local correct walk it back, saturating low
    repeat (5) update(16'h0040, 0, 1, 0);
    step("R6 chooser back to local", 16'h0040, 0, 0, 0, 0, got);
    check("R6 use_global clear", {4'b0, got[0]}, 5'b00000);

    // R7/R8: long taken run saturates counters; history fills with ones
    repeat (10) predict_then_resolve("R7 taken run", 16'h0084, 1);
    step("R7 saturated taken", 16'h0084, 0, 0, 0, 0, got);
    check("R3 global taken after run", {3'b0, got[2], 1'b0}, 5'b00010);
    check("R4 local taken after run", {3'b0, got[1], 1'b0}, 5'b00010);
    // one not-taken outcome must not flip a saturated 3-bit counter
    update(16'h0084, 0, got[2], got[1]);
    repeat (3) predict_then_resolve("R8 history shift", 16'h0084, 1);

    // R9: lookup and update together see pre-update state
    step("R9 same-cycle lookup/update", 16'h0084, 1, 0, 1, 1, got);
    step("R9 following lookup", 16'h0084, 0, 0, 0, 0, got);

    // constrained random: aliasing PCs with per-branch periodic patterns
    for (int i = 0; i < 12; i++) pcs[i] = PC_W'(($urandom & 16'h00FC) | 16'h0100);
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic t;
      k = $urandom_range(0, 11);
      case (k % 3)
        0: t = (n % 4) != 3;
        1: t = $urandom_range(0, 9) < 8;
        default: t = (n % 2) == 0;
      endcase
      if ($urandom_range(0, 15) == 0)
        step("R9 random overlap", pcs[k], 1, t, $urandom_range(0, 1), $urandom_range(0, 1), got);
      else
        predict_then_resolve("R3/R4/R5/R6/R7/R8 random", pcs[k], t);
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule